// File: doc/BRIEF.md
# Seconds Counter with Match Alarms

This block keeps elapsed time as a count of seconds. An external one-per-second pulse advances a 32-bit up-count. A 32-bit down-count moves the opposite way on the same pulse, so when software loads the pair consistently the two always sum to all-ones. Software reads and writes the block over a simple register bus. Writes take effect on the clock edge where the write strobe is high. Read data is combinational from the address.

Two match registers are compared against the up-count. A hit latches a sticky status bit, and software clears that bit by writing a one to it. Each status bit can be routed to the single interrupt output. Each status bit can also drive a logic-level power-on flag, and a control bit can force that flag high. A counter-halt control lets software load the count without a tick landing in the middle of the load. A software-reset control parks both counters. A key register holds a 32-bit value across software reset, so firmware can mark one-time setup as done, for example with 0xB5C13F27.

Top module: `sec_match_timer`

## Requirements
- R1: After power-on reset every register reads zero except the down-count, which reads 0xFFFFFFFF. The byte offsets are: up-count 0x00, down-count 0x04, match0 0x08, match1 0x0C, control 0x10, status 0x14, key 0x18. A read of any other offset returns zero. `irq` and `onsw` are low after reset.
- R2: On each clock edge where `sec_tick` is high and neither halt nor software reset is set, the up-count increments by one and the down-count decrements by one. Both wrap modulo 2^32.
- R3: While halt (control bit 6) is set, no tick is counted, and writes to the up-count and down-count load those counters. While halt is clear, writes to either counter are ignored.
- R4: While software reset (control bit 4) is set, the up-count is held at 0 and the down-count at 0xFFFFFFFF. Control, match and key registers keep their values.
- R5: Status bit i (i = 0 for match0, 1 for match1) sets when the up-count equals match i. This comparison is made only on a cycle in which the up-count changes or match i is written. A status bit therefore stays clear after software clears it while the count sits on the match value.
- R6: Writing the status register clears each status bit whose written bit is 1. Bits written as 0 are unchanged. Software reset does not clear status.
- R7: `irq` is high exactly when (status bit0 and control bit0) or (status bit1 and control bit1). Clearing an enable masks `irq` but leaves the latched status bit set.
- R8: `onsw` is high when control bit7 is set, or when status bit0 is set with control bit2, or when status bit1 is set with control bit3. Status bit2 sets on the clock edge after `onsw` rises.
- R9: The key register stores any 32-bit value written to it, and software reset does not alter it.
- R10: The control register stores bits 0 to 4, 6 and 7. Bit 5 always reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low power-on reset |
| sec_tick | input | 1 | One-cycle pulse, one per second |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Masked match interrupt |
| onsw | output | 1 | Power-on request flag |

## Verification
The bench goes after these corners:

- **Down-count at the wrap.** The count is driven through the 0xFFFFFFFF-to-0 wrap. A design with a wrong down-count direction or a wrong reset value would break the sum to all-ones.
- **Steady match after clear.** The status bit is cleared while the count rests on the match value. A design that compares on every cycle would re-latch the bit at once.
- **Status bit 2 timing.** Status bit 2 is sampled in the cycle between `onsw` rising and the bit latching. An edge detector with the wrong delay, or one that latches on level, shows up here.
- **Counter writes, software reset, key and control bit 5.** Counter writes are issued while halt is clear and must be ignored. The key must survive software reset. Control bit 5 must read back as zero.

Random loads with random match points check the counters and the match logic away from these corners.

// File: rtl/sec_timer_pkg.sv
`timescale 1ns/1ps
package sec_timer_pkg;
    localparam int CNT_W     = 32;
    localparam int NUM_MATCH = 2;
    localparam int STAT_W    = NUM_MATCH + 1;
    localparam int CTL_W     = 8;

    // byte offsets of the register window
    localparam int OFS_UP     = 'h00;
    localparam int OFS_DN     = 'h04;
    localparam int OFS_MAT0   = 'h08;
    localparam int OFS_CTL    = 'h10;
    localparam int OFS_STAT   = 'h14;
    localparam int OFS_KEY    = 'h18;

    // control field positions
    localparam int CB_IRQEN0  = 0;
    localparam int CB_ONEN0   = 2;
    localparam int CB_SRST    = 4;
    localparam int CB_HALT    = 6;
    localparam int CB_FORCE   = 7;
    localparam logic [CTL_W-1:0] CTL_KEEP = 8'hDF;

    localparam int SB_ONSW    = NUM_MATCH;

    typedef struct packed {
        logic [CTL_W-1:0]                   ctl;
        logic [STAT_W-1:0]                  stat;
        logic [CNT_W-1:0]                   key;
        logic [NUM_MATCH-1:0][CNT_W-1:0]    mat;
        logic                               onsw_prev;
    } regs_t;
endpackage

// File: rtl/stc_count_pair.sv
`timescale 1ns/1ps
module stc_count_pair #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         step,
    input  logic         ld_up,
    input  logic         ld_dn,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] up_q,
    output logic [W-1:0] dn_q,
    output logic [W-1:0] up_nx,
    output logic         moved
);
    typedef struct packed {
        logic [W-1:0] up;
        logic [W-1:0] dn;
    } pair_t;

    pair_t cur_q, cur_d;

    always_comb begin
        cur_d = cur_q;
        if (hold) begin
            cur_d.up = '0;
            cur_d.dn = '1;
        end else begin
            if (step) begin
                cur_d.up = cur_q.up + W'(1);
                cur_d.dn = cur_q.dn - W'(1);
            end
            if (ld_up) cur_d.up = ld_val;
            if (ld_dn) cur_d.dn = ld_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.up <= '0;
            cur_q.dn <= '1;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign up_q  = cur_q.up;
    assign dn_q  = cur_q.dn;
    assign up_nx = cur_d.up;
    assign moved = (cur_d.up != cur_q.up);
endmodule

// File: rtl/stc_match_cmp.sv
`timescale 1ns/1ps
module stc_match_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] cnt_nx,
    input  logic [W-1:0] mat_nx,
    input  logic         cnt_moved,
    input  logic         mat_written,
    output logic         hit
);
    // compare only when one side of the comparison changes
    always_comb begin
        hit = (cnt_moved || mat_written) && (cnt_nx == mat_nx);
    end
endmodule

// File: rtl/sec_match_timer.sv
`timescale 1ns/1ps
module sec_match_timer
    import sec_timer_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              onsw
);
    regs_t r_q, r_d;

    logic [CTL_W-1:0]  ctl_q;
    logic [STAT_W-1:0] stat_q;
    logic [CNT_W-1:0]  up_q, dn_q, up_nx;
    logic              moved;
    logic [NUM_MATCH-1:0]            mat_wr, hit;
    logic [NUM_MATCH-1:0][CNT_W-1:0] mat_nx;
    logic              wr_up, wr_dn, wr_ctl, wr_stat, wr_key;
    logic              onsw_now;

    assign ctl_q  = r_q.ctl;
    assign stat_q = r_q.stat;

    assign wr_up   = reg_we && (reg_addr == ADDR_W'(OFS_UP))   && ctl_q[CB_HALT];
    assign wr_dn   = reg_we && (reg_addr == ADDR_W'(OFS_DN))   && ctl_q[CB_HALT];
    assign wr_ctl  = reg_we && (reg_addr == ADDR_W'(OFS_CTL));
    assign wr_stat = reg_we && (reg_addr == ADDR_W'(OFS_STAT));
    assign wr_key  = reg_we && (reg_addr == ADDR_W'(OFS_KEY));

    stc_count_pair #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (ctl_q[CB_SRST]),
        .step   (sec_tick && !ctl_q[CB_HALT] && !ctl_q[CB_SRST]),
        .ld_up  (wr_up),
        .ld_dn  (wr_dn),
        .ld_val (reg_wdata),
        .up_q   (up_q),
        .dn_q   (dn_q),
        .up_nx  (up_nx),
        .moved  (moved)
    );

    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
        assign mat_wr[i] = reg_we && (reg_addr == ADDR_W'(OFS_MAT0 + 4 * i));
        assign mat_nx[i] = mat_wr[i] ? reg_wdata : r_q.mat[i];
        stc_match_cmp #(.W(CNT_W)) u_cmp (
            .cnt_nx      (up_nx),
            .mat_nx      (mat_nx[i]),
            .cnt_moved   (moved),
            .mat_written (mat_wr[i]),
            .hit         (hit[i])
        );
    end

    assign onsw_now = ctl_q[CB_FORCE]
                    | (|(stat_q[NUM_MATCH-1:0] & ctl_q[CB_ONEN0 +: NUM_MATCH]));
    assign irq      = |(stat_q[NUM_MATCH-1:0] & ctl_q[CB_IRQEN0 +: NUM_MATCH]);
    assign onsw     = onsw_now;

    always_comb begin
        logic [STAT_W-1:0] clr;
        logic [STAT_W-1:0] set;
        r_d = r_q;
        clr = wr_stat ? reg_wdata[STAT_W-1:0] : '0;
        set = {onsw_now && !r_q.onsw_prev, hit};
        // a new event wins over a same-cycle clear
        r_d.stat      = (r_q.stat & ~clr) | set;
        r_d.onsw_prev = onsw_now;
        r_d.mat       = mat_nx;
        if (wr_ctl) r_d.ctl = reg_wdata[CTL_W-1:0] & CTL_KEEP;
        if (wr_key) r_d.key = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_UP))   reg_rdata = up_q;
        if (reg_addr == ADDR_W'(OFS_DN))   reg_rdata = dn_q;
        if (reg_addr == ADDR_W'(OFS_CTL))  reg_rdata = CNT_W'(ctl_q);
        if (reg_addr == ADDR_W'(OFS_STAT)) reg_rdata = CNT_W'(stat_q);
        if (reg_addr == ADDR_W'(OFS_KEY))  reg_rdata = r_q.key;
        for (int i = 0; i < NUM_MATCH; i++) begin
            if (reg_addr == ADDR_W'(OFS_MAT0 + 4 * i)) reg_rdata = r_q.mat[i];
        end
    end
endmodule

// File: rtl/sec_match_timer_chk.sv
`timescale 1ns/1ps
module sec_match_timer_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wbit0,
    input logic              irq,
    input logic              onsw,
    input logic [31:0]       up_cnt,
    input logic [31:0]       dn_cnt,
    input logic              halt,
    input logic              srst,
    input logic              force_on,
    input logic [1:0]        irq_en,
    input logic              st0
);
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !halt && !srst) |=>
        (up_cnt == $past(up_cnt) + 32'd1 && dn_cnt == $past(dn_cnt) - 32'd1));

    assert_halt_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !srst && !(reg_we && reg_addr == ADDR_W'(0))) |=> $stable(up_cnt));

    assert_srst_park_R4: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (up_cnt == 32'd0 && dn_cnt == 32'hFFFF_FFFF));

    assert_sticky_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st0 && !(reg_we && reg_addr == ADDR_W'('h14) && wbit0)) |=> st0);

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 2'b00) |-> !irq);

    assert_force_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_on |-> onsw);
endmodule

bind sec_match_timer sec_match_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .wbit0    (reg_wdata[0]),
    .irq      (irq),
    .onsw     (onsw),
    .up_cnt   (up_q),
    .dn_cnt   (dn_q),
    .halt     (ctl_q[6]),
    .srst     (ctl_q[4]),
    .force_on (ctl_q[7]),
    .irq_en   (ctl_q[1:0]),
    .st0      (stat_q[0])
);

// File: tb/sim_sec_match_timer.sv
`timescale 1ns/1ps
module sim_sec_match_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq, onsw;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    sec_match_timer u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .onsw(onsw)
    );

    localparam logic [7:0] A_UP = 8'h00, A_DN = 8'h04, A_M0 = 8'h08, A_M1 = 8'h0C,
                           A_CTL = 8'h10, A_ST = 8'h14, A_KEY = 8'h18;

    function automatic logic [31:0] exp_up(logic [31:0] n, int k);
        return n + 32'(k);
    endfunction
    function automatic logic [31:0] exp_dn(logic [31:0] n, int k);
        return ~n - 32'(k);
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic do_tick(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, n;
        int k, j;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state R1
        rd(A_UP, v);  chk("R1 up", v, 32'h0);
        rd(A_DN, v);  chk("R1 dn", v, 32'hFFFF_FFFF);
        rd(A_M0, v);  chk("R1 m0", v, 32'h0);
        rd(A_M1, v);  chk("R1 m1", v, 32'h0);
        rd(A_CTL, v); chk("R1 ctl", v, 32'h0);
        rd(A_ST, v);  chk("R1 stat", v, 32'h0);
        rd(A_KEY, v); chk("R1 key", v, 32'h0);
        rd(8'h1C, v); chk("R1 unmapped", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 onsw", {31'b0, onsw}, 32'h0);

        // counting R2
        do_tick(3);
        rd(A_UP, v); chk("R2 up", v, 32'd3);
        rd(A_DN, v); chk("R2 dn", v, 32'hFFFF_FFFC);

        // counter writes ignored without halt R3
        do_wr(A_UP, 32'd100);
        rd(A_UP, v); chk("R3 ignored write", v, 32'd3);

        // halt R3
        do_wr(A_CTL, 32'h40);
        do_tick(2);
        rd(A_UP, v); chk("R3 halted", v, 32'd3);
        do_wr(A_UP, 32'hFFFF_FFFE);
        do_wr(A_DN, 32'h1);
        do_wr(A_CTL, 32'h0);
        do_tick(3);
        rd(A_UP, v); chk("R2 wrap up", v, 32'h1);
        rd(A_DN, v); chk("R2 wrap dn", v, 32'hFFFF_FFFE);
        rd(A_ST, v); chk("R5 both match at zero", v, 32'h3);

        // write-one-to-clear R6
        do_wr(A_ST, 32'h1);
        rd(A_ST, v); chk("R6 clear bit0", v, 32'h2);
        do_wr(A_ST, 32'h0);
        rd(A_ST, v); chk("R6 zero write", v, 32'h2);
        do_wr(A_ST, 32'h2);
        rd(A_ST, v); chk("R6 clear bit1", v, 32'h0);

        // match and irq R5 R7
        do_wr(A_M0, 32'd3);
        do_wr(A_CTL, 32'h01);
        do_tick(1);
        rd(A_ST, v); chk("R5 no early hit", v, 32'h0);
        chk("R7 irq low", {31'b0, irq}, 32'h0);
        do_tick(1);
        rd(A_ST, v); chk("R5 hit", v, 32'h1);
        chk("R7 irq high", {31'b0, irq}, 32'h1);
        do_wr(A_CTL, 32'h0);
        chk("R7 masked", {31'b0, irq}, 32'h0);
        rd(A_ST, v); chk("R7 status kept", v, 32'h1);
        do_wr(A_ST, 32'h1);
        repeat (4) @(negedge clk);
        rd(A_ST, v); chk("R5 steady no relatch", v, 32'h0);
        do_wr(A_M1, 32'd3);
        rd(A_ST, v); chk("R5 match write hit", v, 32'h2);
        do_wr(A_ST, 32'h2);

        // power-on flag R8
        do_wr(A_CTL, 32'h04);
        chk("R8 onsw idle", {31'b0, onsw}, 32'h0);
        do_wr(A_M0, 32'd4);
        do_tick(1);
        chk("R8 onsw rises", {31'b0, onsw}, 32'h1);
        rd(A_ST, v); chk("R8 bit2 not yet", v, 32'h1);
        rd(A_ST, v); chk("R8 bit2 latched", v, 32'h5);
        do_wr(A_CTL, 32'h80);
        do_wr(A_ST, 32'h7);
        rd(A_ST, v); chk("R8 no new rise", v, 32'h0);
        chk("R8 forced", {31'b0, onsw}, 32'h1);
        do_wr(A_CTL, 32'h0);
        chk("R8 released", {31'b0, onsw}, 32'h0);

        // software reset R4 R9
        do_wr(A_KEY, 32'hB5C1_3F27);
        do_wr(A_CTL, 32'h10);
        do_tick(2);
        rd(A_UP, v);  chk("R4 up held", v, 32'h0);
        rd(A_DN, v);  chk("R4 dn held", v, 32'hFFFF_FFFF);
        rd(A_M0, v);  chk("R4 m0 kept", v, 32'd4);
        rd(A_M1, v);  chk("R4 m1 kept", v, 32'd3);
        rd(A_CTL, v); chk("R4 ctl kept", v, 32'h10);
        rd(A_KEY, v); chk("R9 key kept", v, 32'hB5C1_3F27);
        do_wr(A_CTL, 32'h0);
        do_tick(2);
        rd(A_UP, v); chk("R4 resumes", v, 32'd2);

        // control bit5 R10
        do_wr(A_CTL, 32'hFF);
        rd(A_CTL, v); chk("R10 bit5 zero", v, 32'hDF);
        do_wr(A_CTL, 32'h0);
        do_wr(A_ST, 32'h7);
        rd(A_ST, v); chk("R6 all cleared", v, 32'h0);

        // random loads and match points R2 R3 R5
        for (int it = 0; it < 20; it++) begin
            n = $urandom;
            k = int'($urandom_range(20, 1));
            j = int'($urandom_range(k, 1));
            do_wr(A_CTL, 32'h40);
            do_wr(A_UP, n);
            do_wr(A_DN, ~n);
            do_wr(A_M0, n + 32'(j));
            do_wr(A_M1, n + 32'(k + 5));
            do_wr(A_ST, 32'h7);
            do_wr(A_CTL, 32'h0);
            do_tick(k);
            rd(A_UP, v); chk("R2 rand up", v, exp_up(n, k));
            rd(A_DN, v); chk("R3 rand dn", v, exp_dn(n, k));
            rd(A_ST, v); chk("R5 rand match", v, 32'h1);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule